// File: doc/BRIEF.md
# PCI Configuration Register File

This block holds the 256-byte configuration space of a PCI type-0 function. A single request port carries a byte offset, a length of one to four bytes and little-endian write data. One cycle later a response comes back. It reports whether the access was accepted and, for reads, returns the addressed bytes. Byte `k` of the data maps to configuration byte `offset + k`.

Writes to the standard header (offsets below 0x40) pass through a fixed write mask for each byte. The high byte of the status register is write-one-to-clear. The expansion ROM register answers an all-ones sizing write with zero, which reports that no ROM is present. Bytes from 0x40 upward are plain storage. Reset fills the array from an arithmetic default pattern set by two parameters. It then forces the decode-enable bits of the command register and the whole ROM register to zero.

The response path is a four-state machine, and its state records what kind of response is being presented:
- `ST_IDLE`: no response.
- `ST_WR_ACK`: a write was accepted.
- `ST_RD_ACK`: a read was accepted and `rsp_rdata` holds its bytes.
- `ST_REJECT`: the access was refused.

Every state moves to `ST_REJECT` on an illegal request, to `ST_WR_ACK` on a legal write, to `ST_RD_ACK` on a legal read, and to `ST_IDLE` when there is no request. Requests may arrive back to back.

Top module: `cfg_space_regfile`

## Requirements
- R1: Command register bytes: every bit of offset 0x04 is writable, and only bits 2:0 of offset 0x05 are writable. The remaining bits keep their value.
- R2: The status low byte (0x06) and every header byte not named in R1, R3, R4 or R5 are read-only. This covers 0x00-0x03, 0x08-0x0B, 0x0D-0x0F, 0x28-0x2F, 0x34-0x3B and 0x3D-0x3F.
- R3: The status high byte (0x07) has clear-on-one bits under mask 0xF9. A 1 written to one of those bits clears it, a 0 leaves it alone, and no bit of the byte can ever be set by a write.
- R4: Offset 0x0C, offsets 0x10 to 0x27 and offset 0x3C are fully writable.
- R5: The ROM register bytes 0x30, 0x31, 0x32 and 0x33 use write masks 0x01, 0xF8, 0xFF and 0xFF.
- R6: A four-byte write at offset 0x30 whose data bits 31:11 are all ones leaves all four ROM bytes reading zero.
- R7: Bytes at offset 0x40 and above store the written value unmasked.
- R8: An access with length 0, length above 4, or offset + length above 256 gets `rsp_err` = 1 and `rsp_rdata` = 0, and changes no byte.
- R9: After reset, byte `i` reads `(i*73 + 0x5B) mod 256`, with two exceptions: bits 2:0 of byte 0x04 are zero, and bytes 0x30-0x33 are zero. No response is pending.
- R10: Each request gets exactly one response with `rsp_valid` = 1 in the next cycle. For an accepted read, data lane `k` holds byte `offset + k` for `k` < length, and the unused lanes are zero. Accepted writes return zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 9 | Byte offset of the first byte |
| req_len | input | 3 | Number of bytes, legal 1 to 4 |
| req_wdata | input | 32 | Write data, lane k goes to offset + k |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Request was rejected |
| rsp_rdata | output | 32 | Read data, zero for writes and rejects |

## Verification
The hardest case to reach from the ports is the clear-on-one status byte. Its bits can only fall, so once they are cleared nothing at the ports can bring them back. Any later stimulus aimed at them sees an all-zero byte.

The bench therefore gives the status byte its own directed writes while the reset pattern is still intact: first a write of zeros, then a single-bit clear, then a full clear. Only after that does it run the exhaustive write sweep and the pseudo-random multi-byte traffic. A reference array in the bench tracks every write, so straddling writes that cross the command, status and ROM boundaries are compared against the rules written out in the requirements.

// File: rtl/cfgspace_pkg.sv
package cfgspace_pkg;

    localparam int HDR_BYTES = 64;
    localparam int CMD_LO    = 4;
    localparam int CMD_HI    = 5;
    localparam int STS_LO    = 6;
    localparam int STS_HI    = 7;
    localparam int CLS_OFF   = 12;
    localparam int BAR_FIRST = 16;
    localparam int BAR_LAST  = 39;
    localparam int ROM_OFF   = 48;
    localparam int IRQ_LINE  = 60;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WR_ACK,
        ST_RD_ACK,
        ST_REJECT
    } rsp_state_e;

    // Writable bits of one configuration byte.
    function automatic logic [7:0] wr_mask(input int unsigned a);
        logic [7:0] m;
        m = 8'h00;
        if (a >= HDR_BYTES) begin
            m = 8'hFF;
        end else if (a == CMD_LO || a == CLS_OFF || a == IRQ_LINE) begin
            m = 8'hFF;
        end else if (a == CMD_HI) begin
            m = 8'h07;
        end else if (a == STS_HI) begin
            m = 8'hF9;
        end else if (a >= BAR_FIRST && a <= BAR_LAST) begin
            m = 8'hFF;
        end else if (a == ROM_OFF) begin
            m = 8'h01;
        end else if (a == ROM_OFF + 1) begin
            m = 8'hF8;
        end else if (a == ROM_OFF + 2 || a == ROM_OFF + 3) begin
            m = 8'hFF;
        end
        return m;
    endfunction

    function automatic logic is_clear_on_one(input int unsigned a);
        return a == STS_HI;
    endfunction

endpackage

// File: rtl/cfg_byte_lane.sv
module cfg_byte_lane #(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        old_byte,
    input  logic [7:0]        wr_byte,
    output logic [7:0]        new_byte
);
    import cfgspace_pkg::*;

    logic [7:0] m;
    logic [7:0] hit;

    always_comb begin
        m   = wr_mask(32'(addr));
        hit = wr_byte & m;
        if (is_clear_on_one(32'(addr))) begin
            new_byte = old_byte & ~hit;
        end else begin
            new_byte = (old_byte & ~m) | hit;
        end
    end
endmodule

// File: rtl/cfg_access_check.sv
module cfg_access_check #(
    parameter int CFG_BYTES = 256,
    parameter int OFF_W     = 9,
    parameter int LEN_W     = 3,
    parameter int LANES     = 4
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [LEN_W-1:0] len,
    output logic             ok,
    output logic [LANES-1:0] lane_en
);
    logic [OFF_W:0] end_pos;

    always_comb begin
        end_pos = {1'b0, offset} + (OFF_W+1)'(len);
        ok = (len != '0) && (32'(len) <= LANES) && (32'(end_pos) <= CFG_BYTES);
    end

    for (genvar k = 0; k < LANES; k++) begin : g_en
        assign lane_en[k] = 32'(len) > k;
    end
endmodule

// File: rtl/cfg_space_regfile.sv
module cfg_space_regfile #(
    parameter int CFG_BYTES = 256,
    parameter int LEN_W     = 3,
    parameter int DFLT_MUL  = 73,
    parameter int DFLT_ADD  = 91
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [8:0]  req_offset,
    input  logic [2:0]  req_len,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic        rsp_err,
    output logic [31:0] rsp_rdata
);
    import cfgspace_pkg::*;

    localparam int LANES    = 4;
    localparam int DATA_W   = LANES * 8;
    localparam int ADDR_W   = $clog2(CFG_BYTES);
    localparam int OFF_W    = ADDR_W + 1;
    localparam logic [DATA_W-1:0] ROM_ADDR_BITS = 32'hFFFF_F800;

    logic [7:0]        mem [CFG_BYTES];
    logic [DATA_W-1:0] rd_q;
    logic              acc_ok;
    logic [LANES-1:0]  lane_en;
    logic [ADDR_W-1:0] lane_addr [LANES];
    logic [7:0]        lane_new  [LANES];
    logic              wr_go;
    logic              rom_clear;
    rsp_state_e        state_q, state_d;

    function automatic logic [7:0] reset_byte(input int i);
        logic [7:0] b;
        b = 8'(i * DFLT_MUL + DFLT_ADD);
        if (i == CMD_LO) b[2:0] = 3'b000;
        if (i >= ROM_OFF && i < ROM_OFF + 4) b = 8'h00;
        return b;
    endfunction

    cfg_access_check #(
        .CFG_BYTES(CFG_BYTES), .OFF_W(OFF_W), .LEN_W(LEN_W), .LANES(LANES)
    ) u_check (
        .offset (req_offset),
        .len    (req_len),
        .ok     (acc_ok),
        .lane_en(lane_en)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [OFF_W:0] sum;
        assign sum          = {1'b0, req_offset} + (OFF_W+1)'(k);
        assign lane_addr[k] = sum[ADDR_W-1:0];
        cfg_byte_lane #(.ADDR_W(ADDR_W)) u_lane (
            .addr    (lane_addr[k]),
            .old_byte(mem[lane_addr[k]]),
            .wr_byte (req_wdata[k*8 +: 8]),
            .new_byte(lane_new[k])
        );
    end

    assign wr_go     = req_valid && req_write && acc_ok;
    assign rom_clear = (32'(req_offset) == ROM_OFF) && (req_len == 3'd4)
                    && ((req_wdata & ROM_ADDR_BITS) == ROM_ADDR_BITS);

    // Storage array.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < CFG_BYTES; i++) mem[i] <= reset_byte(i);
        end else if (wr_go) begin
            if (rom_clear) begin
                for (int j = 0; j < 4; j++) mem[ROM_OFF + j] <= 8'h00;
            end else begin
                for (int k = 0; k < LANES; k++) begin
                    if (lane_en[k]) mem[lane_addr[k]] <= lane_new[k];
                end
            end
        end
    end

    // Read data register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (req_valid) begin
            rd_q <= '0;
            if (acc_ok && !req_write) begin
                for (int k = 0; k < LANES; k++) begin
                    if (lane_en[k]) rd_q[k*8 +: 8] <= mem[lane_addr[k]];
                end
            end
        end
    end

    // Response state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state.
    always_comb begin
        state_d = ST_IDLE;
        if (req_valid) begin
            if (!acc_ok)        state_d = ST_REJECT;
            else if (req_write) state_d = ST_WR_ACK;
            else                state_d = ST_RD_ACK;
        end
    end

    // Outputs decoded from state.
    always_comb begin
        rsp_valid = 1'b1;
        rsp_err   = 1'b0;
        unique case (state_q)
            ST_IDLE:   rsp_valid = 1'b0;
            ST_WR_ACK: rsp_err   = 1'b0;
            ST_RD_ACK: rsp_err   = 1'b0;
            ST_REJECT: rsp_err   = 1'b1;
            default:   rsp_valid = 1'b0;
        endcase
    end
    assign rsp_rdata = rd_q;

    AST_CMD_HI_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(mem[CMD_HI][7:3])); // R1
    AST_STS_LO_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(mem[STS_LO])); // R2
    AST_STS_HI_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((mem[STS_HI] & ~$past(mem[STS_HI])) == 8'h00)); // R3
    AST_ROM_LOW_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(mem[ROM_OFF][7:1])); // R5
    AST_ROM_SIZING_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && 32'(req_offset) == ROM_OFF && req_len == 3'd4
         && ((req_wdata & ROM_ADDR_BITS) == ROM_ADDR_BITS))
        |=> (mem[ROM_OFF] == 8'h00 && mem[ROM_OFF + 3] == 8'h00)); // R6
    AST_REJECT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == '0)); // R8
    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R10
endmodule

// File: tb/cfg_space_regfile_tb.sv
`timescale 1ns/1ps
module cfg_space_regfile_tb;
    localparam int N = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [8:0]  req_offset = '0;
    logic [2:0]  req_len = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    logic [7:0] mdl [N];

    always #2 clk = ~clk;

    cfg_space_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_offset(req_offset), .req_len(req_len), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    function automatic logic [7:0] bmask(input int a);
        if (a >= 64) return 8'hFF;
        if (a == 4 || a == 12 || a == 60) return 8'hFF;
        if (a == 5) return 8'h07;
        if (a == 7) return 8'hF9;
        if (a >= 16 && a <= 39) return 8'hFF;
        if (a == 48) return 8'h01;
        if (a == 49) return 8'hF8;
        if (a == 50 || a == 51) return 8'hFF;
        return 8'h00;
    endfunction

    function automatic string tag_of(input int a);
        if (a >= 64) return "R7";
        if (a == 4 || a == 5) return "R1";
        if (a == 7) return "R3";
        if (a >= 48 && a <= 51) return "R5";
        if (bmask(a) == 8'hFF) return "R4";
        return "R2";
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic op(input bit wr, input int off, input int len,
                      input logic [31:0] d, input string tag);
        bit bad;
        logic [31:0] exp;
        bad = (len < 1) || (len > 4) || (off + len > N);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_offset = 9'(off);
        req_len = 3'(len); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R10 valid"}, 32'(rsp_valid), 32'd1);
        chk({tag, " err"}, 32'(rsp_err), 32'(bad));
        exp = '0;
        if (!bad) begin
            if (wr) begin
                if (off == 48 && len == 4 && d[31:11] == 21'h1FFFFF) begin
                    for (int j = 0; j < 4; j++) mdl[48 + j] = 8'h00;
                end else begin
                    for (int k = 0; k < len; k++) begin
                        logic [7:0] m, b;
                        m = bmask(off + k);
                        b = d[k*8 +: 8];
                        if (off + k == 7) mdl[7] = mdl[7] & ~(b & m);
                        else mdl[off + k] = (mdl[off + k] & ~m) | (b & m);
                    end
                end
            end else begin
                for (int k = 0; k < len; k++) exp[k*8 +: 8] = mdl[off + k];
            end
        end
        chk({tag, " data"}, rsp_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired got running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] lf;
        #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        for (int i = 0; i < N; i++) begin
            mdl[i] = 8'(i * 73 + 91);
            if (i == 4) mdl[i][2:0] = 3'b000;
            if (i >= 48 && i < 52) mdl[i] = 8'h00;
        end
        @(negedge clk);
        chk("R9 idle", {30'd0, rsp_valid, rsp_err}, 32'd0);
        for (int a = 0; a < N; a += 4) op(1'b0, a, 4, '0, "R9 reset");

        // status clear-on-one directed
        op(1'b1, 7, 1, 32'h00, "R3 zero");
        op(1'b0, 7, 1, '0, "R3");
        op(1'b1, 6, 2, 32'h0800, "R3 one bit");
        op(1'b0, 4, 4, '0, "R3");
        op(1'b1, 7, 1, 32'hFF, "R3 all");
        op(1'b0, 7, 1, '0, "R3");

        // ROM sizing
        op(1'b1, 48, 4, 32'h1234_5679, "R5 write");
        op(1'b0, 48, 4, '0, "R5");
        op(1'b1, 48, 4, 32'hFFFF_FFFF, "R6 sizing");
        op(1'b0, 48, 4, '0, "R6");
        op(1'b1, 48, 4, 32'hFFFF_F800, "R6 sizing min");
        op(1'b0, 48, 4, '0, "R6");
        op(1'b1, 48, 4, 32'hFFFF_F000, "R5 near");
        op(1'b0, 48, 4, '0, "R5");

        // rejects
        op(1'b1, 254, 4, 32'hFFFF_FFFF, "R8 overrun");
        op(1'b0, 252, 4, '0, "R8 keep");
        op(1'b1, 16, 5, 32'hFFFF_FFFF, "R8 len5");
        op(1'b1, 60, 0, 32'hFFFF_FFFF, "R8 len0");
        op(1'b1, 256, 1, 32'hFF, "R8 offset");
        op(1'b0, 100, 7, '0, "R8 read");
        op(1'b0, 16, 4, '0, "R8 keep");
        op(1'b0, 60, 4, '0, "R8 keep");

        // exhaustive byte sweep
        for (int a = 0; a < N; a++) begin
            op(1'b1, a, 1, 32'hFF, tag_of(a));
            op(1'b0, a, 1, '0, tag_of(a));
            op(1'b1, a, 1, 32'h00, tag_of(a));
            op(1'b0, a, 1, '0, tag_of(a));
            op(1'b1, a, 1, 32'(8'(a ^ 8'h5A)), tag_of(a));
            op(1'b0, a, 1, '0, tag_of(a));
        end

        // pseudo-random multi-byte traffic
        lf = 32'h1ACE_B00C;
        for (int n = 0; n < 600; n++) begin
            int off, len;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            off = int'(lf[7:0]);
            len = 1 + int'(lf[9:8]);
            if (lf[12:10] == 3'd0) len = 5 + int'(lf[11]);
            op(lf[13], off, len, {lf[23:0], lf[31:24]}, tag_of(off));
            op(1'b0, off & 252, 4, '0, tag_of(off));
        end
        op(1'b0, 0, 4, '0, "R10 read");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule